// File: doc/BRIEF.md
# Descriptor-Chained Bus-Master DMA Engine

This engine moves disk data between a local sector buffer and host memory. It takes its instructions from a table of descriptors held in host memory. Software supplies four things: the table's start address, the total byte count of the command, a direction, and a one-cycle start strobe. The engine reads each 8-byte descriptor through a 32-bit memory read port. It then issues one halfword (2-byte) request per beat for the region that the descriptor names. Each beat carries the host address and the matching offset into the local buffer.

Each descriptor has two little-endian 32-bit words. The word at offset 0 is the region base address. The word at offset 4 carries the byte count in bits 15:0 and a flags halfword in bits 31:16. The walk stops after the region whose descriptor has the end-of-table flag set. When the regions and the command byte count disagree, the engine stops and flags an error. It reports completion with a single-cycle done pulse, and an abort input drops it back to idle at any time.

Top module: `desc_dma_engine`

## Requirements
- R1: After reset, busy, done, error, rdReq and memReq are all 0.
- R2: A start in idle fetches the first descriptor with two reads, at the table address and the table address + 4. Each later descriptor is read at the previous descriptor address + 8. Only one of rdReq and memReq is high at a time.
- R3: Bit 0 of the region base word is forced to 0. Beat addresses start at that even base and rise by 2 per accepted beat.
- R4: Bit 0 of the byte count (word 1 bits 15:0) is ignored, so a region of count C takes floor(C/2) beats. A count of 1 is a zero-length region with no beats.
- R5: A byte count of 0 means 131072 bytes, which is 65536 beats.
- R6: Bit 31 of word 1 (flags bit 15) marks the last descriptor. No read is issued after that region ends.
- R7: memWe equals the toMemory input latched at start, for every beat of the operation. 1 means device to memory.
- R8: error is set, and done still pulses, in either of two cases: the regions run out before the command byte count (bit 0 ignored), or the command count runs out while a region has bytes left or before the last descriptor. error is cleared by the next start.
- R9: done is high for exactly one cycle per completed operation, and busy is 0 in that cycle and afterwards.
- R10: abort returns the engine to idle in the next cycle from any state, with busy, rdReq and memReq at 0 and no done pulse. A new start then works normally.
- R11: memReq stays high with a stable memAddr until memAck is seen, so memory back-pressure only stretches the transfer.
- R12: bufOffset is 0 on the first beat and rises by 2 per beat across all regions of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, taken only in idle |
| abort | input | 1 | Return to idle at once |
| toMemory | input | 1 | 1 = device to memory, 0 = memory to device |
| tableBase | input | ADDR_W | Address of the first descriptor |
| cmdBytes | input | CMD_W | Total bytes of the command (bit 0 ignored) |
| rdReq | output | 1 | Descriptor word read request, held until rdValid |
| rdAddr | output | ADDR_W | Descriptor word address |
| rdValid | input | 1 | Read data valid; completes the read |
| rdData | input | 32 | Descriptor word |
| memReq | output | 1 | Data beat request, held until memAck |
| memWe | output | 1 | 1 = beat writes host memory |
| memAddr | output | ADDR_W | Host address of the beat |
| bufOffset | output | OFS_W | Sector buffer byte offset of the beat |
| memAck | input | 1 | Beat accepted |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Length mismatch of the last operation |

## Verification
Every handshake completes at the clock edge where both request and response are high. The bench therefore drives responses on the falling edge and logs each beat and fetch in that same half cycle, when memAddr, memWe and bufOffset are steady. A region ending on its final accepted beat shows done exactly one clock later, because the region-empty test is taken from registered counters. The bench waits for done and then samples busy and error one falling edge further on. An abort is checked at the first falling edge after the edge that sampled it.

// File: rtl/dma_walk_pkg.sv
package dma_walk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;   // latch command and table pointer
    logic fetchHi;  // second descriptor word is being read
    logic takeLo;   // capture region base
    logic takeHi;   // capture count and flags, step table pointer
    logic beat;     // one halfword accepted
  } walkCtl_t;

  localparam int unsigned BEAT_BYTES = 2;
  localparam int unsigned DESC_BYTES = 8;

endpackage

// File: rtl/dma_walk_path.sv
module dma_walk_path
  import dma_walk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CMD_W      = 24,
  parameter int unsigned OFS_W      = 24,
  parameter int unsigned MAX_REGION = 131072
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [CMD_W-1:0]  cmdBytes,
  input  logic              dirIn,
  input  logic [31:0]       rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [OFS_W-1:0]  bufOffset,
  output logic              memWe,
  output logic              regionEmpty,
  output logic              cmdEmpty,
  output logic              lastDesc
);

  localparam int unsigned LEN_W = $clog2(MAX_REGION) + 1;

  logic [ADDR_W-1:0] descPtr;
  logic [ADDR_W-1:0] regAddr;
  logic [LEN_W-1:0]  regLeft;
  logic [CMD_W-1:0]  cmdLeft;
  logic [15:0]       rawCount;
  logic [LEN_W-1:0]  decodedLen;

  assign rawCount   = rdData[15:0];
  assign decodedLen = (rawCount == 16'd0) ? LEN_W'(MAX_REGION)
                                          : LEN_W'({rawCount[15:1], 1'b0});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descPtr   <= '0;
      regAddr   <= '0;
      regLeft   <= '0;
      cmdLeft   <= '0;
      bufOffset <= '0;
      memWe     <= 1'b0;
      lastDesc  <= 1'b0;
    end else begin
      if (ctl.launch) begin
        descPtr   <= tableBase;
        cmdLeft   <= {cmdBytes[CMD_W-1:1], 1'b0};
        bufOffset <= '0;
        memWe     <= dirIn;
        regLeft   <= '0;
        lastDesc  <= 1'b0;
      end
      if (ctl.takeLo) begin
        regAddr <= {rdData[ADDR_W-1:1], 1'b0};
      end
      if (ctl.takeHi) begin
        regLeft  <= decodedLen;
        lastDesc <= rdData[31];
        descPtr  <= descPtr + ADDR_W'(DESC_BYTES);
      end
      if (ctl.beat) begin
        regAddr   <= regAddr + ADDR_W'(BEAT_BYTES);
        regLeft   <= regLeft - LEN_W'(BEAT_BYTES);
        cmdLeft   <= cmdLeft - CMD_W'(BEAT_BYTES);
        bufOffset <= bufOffset + OFS_W'(BEAT_BYTES);
      end
    end
  end

  assign rdAddr      = descPtr + (ctl.fetchHi ? ADDR_W'(4) : ADDR_W'(0));
  assign memAddr     = regAddr;
  assign regionEmpty = (regLeft == '0);
  assign cmdEmpty    = (cmdLeft == '0);

endmodule

// File: rtl/dma_walk_ctrl.sv
module dma_walk_ctrl
  import dma_walk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     abort,
  input  logic     rdValid,
  input  logic     memAck,
  input  logic     regionEmpty,
  input  logic     cmdEmpty,
  input  logic     lastDesc,
  output walkCtl_t ctl,
  output logic     rdReq,
  output logic     memReq,
  output logic     busy,
  output logic     done,
  output logic     error
);

  walkState_t state;
  logic       fetchHi;
  logic       finish;
  logic       finErr;

  assign rdReq  = (state == ST_FETCH);
  assign memReq = (state == ST_XFER) && !regionEmpty && !cmdEmpty;
  assign busy   = (state != ST_IDLE);

  always_comb begin
    ctl         = '0;
    ctl.launch  = (state == ST_IDLE) && start && !abort;
    ctl.fetchHi = fetchHi;
    ctl.takeLo  = rdReq && rdValid && !fetchHi && !abort;
    ctl.takeHi  = rdReq && rdValid && fetchHi && !abort;
    ctl.beat    = memReq && memAck && !abort;
  end

  // a region ended with the table exhausted, or the command ran dry
  assign finish = (state == ST_XFER) &&
                  (regionEmpty ? (lastDesc || cmdEmpty) : cmdEmpty);
  assign finErr = !(regionEmpty && lastDesc && cmdEmpty);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      fetchHi <= 1'b0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        state   <= ST_IDLE;
        fetchHi <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (ctl.launch) begin
              state   <= ST_FETCH;
              fetchHi <= 1'b0;
              error   <= 1'b0;
            end
          end
          ST_FETCH: begin
            if (rdValid) begin
              if (fetchHi) begin
                state   <= ST_XFER;
                fetchHi <= 1'b0;
              end else begin
                fetchHi <= 1'b1;
              end
            end
          end
          ST_XFER: begin
            if (finish) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              error <= finErr;
            end else if (regionEmpty) begin
              state <= ST_FETCH;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/desc_dma_engine.sv
module desc_dma_engine
  import dma_walk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CMD_W      = 24,
  parameter int unsigned OFS_W      = 24,
  parameter int unsigned MAX_REGION = 131072
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              abort,
  input  logic              toMemory,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [CMD_W-1:0]  cmdBytes,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [31:0]       rdData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [OFS_W-1:0]  bufOffset,
  input  logic              memAck,
  output logic              busy,
  output logic              done,
  output logic              error
);

  walkCtl_t ctl;
  logic     regionEmpty;
  logic     cmdEmpty;
  logic     lastDesc;

  dma_walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .abort       (abort),
    .rdValid     (rdValid),
    .memAck      (memAck),
    .regionEmpty (regionEmpty),
    .cmdEmpty    (cmdEmpty),
    .lastDesc    (lastDesc),
    .ctl         (ctl),
    .rdReq       (rdReq),
    .memReq      (memReq),
    .busy        (busy),
    .done        (done),
    .error       (error)
  );

  dma_walk_path #(
    .ADDR_W     (ADDR_W),
    .CMD_W      (CMD_W),
    .OFS_W      (OFS_W),
    .MAX_REGION (MAX_REGION)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .tableBase   (tableBase),
    .cmdBytes    (cmdBytes),
    .dirIn       (toMemory),
    .rdData      (rdData),
    .rdAddr      (rdAddr),
    .memAddr     (memAddr),
    .bufOffset   (bufOffset),
    .memWe       (memWe),
    .regionEmpty (regionEmpty),
    .cmdEmpty    (cmdEmpty),
    .lastDesc    (lastDesc)
  );

endmodule

// File: rtl/desc_dma_engine_chk.sv
module desc_dma_engine_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              abort,
  input logic              rdReq,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy,
  input logic              done
);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !abort) |=> (memReq && $stable(memAddr)));

  p_even_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !memAddr[0]);

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!busy && !memReq && !rdReq));

  p_one_port_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && rdReq));

endmodule

bind desc_dma_engine desc_dma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .abort   (abort),
  .rdReq   (rdReq),
  .memReq  (memReq),
  .memAck  (memAck),
  .memAddr (memAddr),
  .busy    (busy),
  .done    (done)
);

// File: tb/sim_desc_dma_engine.sv
module sim_desc_dma_engine;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TB_BASE = 32'h40;

  typedef struct packed {
    logic [31:0] d0b, d0w, d1b, d1w, d2b, d2w;
    logic [31:0] cmd;
    logic        dir;
    logic        stall;
    logic        expErr;
    logic [31:0] expBeats;
    logic [31:0] expFetch;
    logic [31:0] expFirst;
    logic [31:0] expLast;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    // single last region, exact fit
    '{32'h1000, 32'h8000_0008, 0, 0, 0, 0, 32'd8, 1'b1, 1'b0, 1'b0, 32'd4, 32'd2, 32'h1000, 32'h1006},
    // odd base and odd count, two regions, stalled acks
    '{32'h2001, 32'h0000_0007, 32'h3000, 32'h8000_0004, 0, 0, 32'd10, 1'b0, 1'b1, 1'b0, 32'd5, 32'd4, 32'h2000, 32'h3002},
    // regions shorter than command
    '{32'h0500, 32'h8000_0004, 0, 0, 0, 0, 32'd8, 1'b1, 1'b0, 1'b1, 32'd2, 32'd2, 32'h0500, 32'h0502},
    // region longer than command
    '{32'h0600, 32'h8000_0008, 0, 0, 0, 0, 32'd4, 1'b0, 1'b0, 1'b1, 32'd2, 32'd2, 32'h0600, 32'h0602},
    // zero-length middle region (count 1)
    '{32'h0700, 32'h0000_0002, 32'h0800, 32'h0000_0001, 32'h0900, 32'h8000_0002, 32'd4, 1'b1, 1'b1, 1'b0, 32'd2, 32'd6, 32'h0700, 32'h0900},
    // command ends before last descriptor
    '{32'h0A00, 32'h0000_0004, 32'h0B00, 32'h8000_0004, 0, 0, 32'd4, 1'b1, 1'b0, 1'b1, 32'd2, 32'd2, 32'h0A00, 32'h0A02}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        abort = 1'b0;
  logic        toMemory = 1'b0;
  logic [31:0] tableBase = TB_BASE;
  logic [23:0] cmdBytes = '0;
  logic        rdReq;
  logic [31:0] rdAddr;
  logic        rdValid = 1'b0;
  logic [31:0] rdData = '0;
  logic        memReq;
  logic        memWe;
  logic [31:0] memAddr;
  logic [23:0] bufOffset;
  logic        memAck = 1'b0;
  logic        busy;
  logic        done;
  logic        error;

  desc_dma_engine u0 (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort), .toMemory(toMemory),
    .tableBase(tableBase), .cmdBytes(cmdBytes), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .bufOffset(bufOffset), .memAck(memAck), .busy(busy),
    .done(done), .error(error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  logic [31:0] descMem [8];
  logic        stallMode = 1'b0;
  logic        stallTog = 1'b0;
  logic        expDir = 1'b0;
  int          beats, fetches, doneSeen, badFetch, badDir, badOfs;
  logic [31:0] firstAddr, lastAddr;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  // responder and monitor, all on the falling edge
  always @(negedge clk) begin
    stallTog <= ~stallTog;
    rdValid = rdReq;
    if (rdReq) begin
      if (rdAddr !== TB_BASE + 32'(4 * fetches)) badFetch++;
      rdData = (rdAddr >= TB_BASE && rdAddr < TB_BASE + 32) ? descMem[(rdAddr - TB_BASE) >> 2] : 32'hDEAD_BEEF;
      fetches++;
    end
    memAck = memReq && (!stallMode || stallTog);
    if (memAck) begin
      if (beats == 0) firstAddr = memAddr;
      lastAddr = memAddr;
      if (memWe !== expDir) badDir++;
      if (bufOffset !== 24'(2 * beats)) badOfs++;
      beats++;
    end
    if (done) doneSeen++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
      finishRun();
    end
  end

  task automatic clearMon();
    beats = 0; fetches = 0; doneSeen = 0; badFetch = 0; badDir = 0; badOfs = 0;
    firstAddr = '0; lastAddr = '0;
  endtask

  task automatic launch(input logic [31:0] cmd, input logic dir);
    @(negedge clk);
    clearMon();
    expDir = dir;
    toMemory = dir;
    cmdBytes = cmd[23:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input int limit);
    for (int i = 0; i < limit && doneSeen == 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    clearMon();
    for (int i = 0; i < 8; i++) descMem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "error", 32'(error), 0);
    chk("R1", "rdReq", 32'(rdReq), 0);
    chk("R1", "memReq", 32'(memReq), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      descMem[0] = VECS[v].d0b; descMem[1] = VECS[v].d0w;
      descMem[2] = VECS[v].d1b; descMem[3] = VECS[v].d1w;
      descMem[4] = VECS[v].d2b; descMem[5] = VECS[v].d2w;
      stallMode = VECS[v].stall;
      launch(VECS[v].cmd, VECS[v].dir);
      waitDone(2000);
      chk("R4_R11", "beat count", 32'(beats), VECS[v].expBeats);
      chk("R3", "first beat address", firstAddr, VECS[v].expFirst);
      chk("R3", "last beat address", lastAddr, VECS[v].expLast);
      chk("R6", "descriptor words read", 32'(fetches), VECS[v].expFetch);
      chk("R2", "fetch address mismatches", 32'(badFetch), 0);
      chk("R7", "direction mismatches", 32'(badDir), 0);
      chk("R12", "buffer offset mismatches", 32'(badOfs), 0);
      chk("R8", "error flag", 32'(error), 32'(VECS[v].expErr));
      chk("R9", "done pulses", 32'(doneSeen), 1);
      chk("R9", "busy after done", 32'(busy), 0);
    end
    stallMode = 1'b0;

    // R5: count field of zero means 131072 bytes
    descMem[0] = 32'h0001_0000; descMem[1] = 32'h8000_0000;
    launch(32'd131072, 1'b0);
    waitDone(70000);
    chk("R5", "beats for zero count", 32'(beats), 32'd65536);
    chk("R5", "last address for zero count", lastAddr, 32'h0002_FFFE);
    chk("R5", "error for zero count", 32'(error), 0);

    // R10: abort in the middle of a transfer
    descMem[0] = 32'h1000; descMem[1] = 32'h8000_0010;
    launch(32'd16, 1'b1);
    for (int i = 0; i < 100 && beats < 3; i++) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R10", "busy after abort", 32'(busy), 0);
    chk("R10", "memReq after abort", 32'(memReq), 0);
    chk("R10", "rdReq after abort", 32'(rdReq), 0);
    repeat (10) @(negedge clk);
    chk("R10", "done pulses after abort", 32'(doneSeen), 0);

    // R10: abort during descriptor fetch
    launch(32'd16, 1'b1);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R10", "busy after fetch abort", 32'(busy), 0);

    // R10: engine restarts cleanly after abort
    descMem[0] = 32'h1000; descMem[1] = 32'h8000_0008;
    launch(32'd8, 1'b1);
    waitDone(200);
    chk("R10", "beats after restart", 32'(beats), 4);
    chk("R10", "done after restart", 32'(doneSeen), 1);
    chk("R8", "error cleared by start", 32'(error), 0);

    finishRun();
  end

endmodule